// File: doc/BRIEF.md
# 32-bit Arithmetic-Logic Unit with Signed Compares

This block is the purely combinational arithmetic-logic unit of a single-cycle 32-bit RISC datapath. Two 32-bit operands and a 4-bit operation code go in. A 32-bit result and a flag that marks an all-zero result come out in the same cycle. No register sits on any path through the block.

The operation set covers the usual arithmetic, shift and bitwise functions. It adds NAND and a signed greater-than compare, and it has a pass-through mode. The pass-through hands operand A straight to the result so that the datapath can route a register value to the program counter as a jump target. Instruction decoding, the register file and the memories sit outside this block.

One subtractor serves subtraction and both signed compares. A log-depth barrel shifter handles the two shift directions. A single result multiplexer, keyed on the operation code, picks the output.

Top module: `alu32`

## Requirements
- R1: Code 0000 gives the sum of A and B modulo 2^32, so a carry out of bit 31 is dropped.
- R2: Code 0001 gives A minus B modulo 2^32, so a borrow wraps around.
- R3: Code 0010 shifts A left by the amount held in B[4:0] and fills with zeros. Bits B[31:5] have no effect on the result.
- R4: Code 0011 shifts A right by B[4:0] as a logical shift, so zeros enter at bit 31. Bits B[31:5] have no effect on the result.
- R5: Codes 0100, 0101 and 0110 give the bitwise AND, OR and XOR of A and B.
- R6: Code 0111 gives the bitwise NOR of A and B, and code 1000 gives the bitwise NAND.
- R7: Code 1001 gives 1 when A is less than B under signed two's-complement ordering and 0 otherwise. Bits 31 to 1 of the result are always 0.
- R8: Code 1010 gives 1 when A is greater than B under signed two's-complement ordering and 0 otherwise. Equal operands give 0.
- R9: Code 1011 passes A unchanged to the result, whatever B is.
- R10: Codes 1100 to 1111 give a result of 0 for any operands.
- R11: The zero flag is 1 exactly when the 32-bit result is 0. This holds for every operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand, also the pass-through source |
| b_i | input | 32 | Second operand; bits 4:0 give the shift amount |
| result_o | output | 32 | Result of the selected operation |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench targets signed-compare pairs where A minus B overflows, such as the most negative value against the most positive. A compare that read only the sign bit of the difference would return the inverted answer on those pairs. Shift amounts of 0 and 31 are driven, along with B values whose upper bits are set. A shifter that read more than five bits would return 0 where A or a small shift is expected, and an arithmetic right shift would copy a set bit 31 into the vacated positions. Equal operands go to both compares, to catch a greater-than built as not-less-than. Unused codes are driven with non-zero operands, and the zero flag is checked against the reference on every vector, including pass-through of a zero A.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'b0000,
        OP_SUB  = 4'b0001,
        OP_SHL  = 4'b0010,
        OP_SHR  = 4'b0011,
        OP_AND  = 4'b0100,
        OP_OR   = 4'b0101,
        OP_XOR  = 4'b0110,
        OP_NOR  = 4'b0111,
        OP_NAND = 4'b1000,
        OP_LT   = 4'b1001,
        OP_GT   = 4'b1010,
        OP_PASS = 4'b1011
    } alu_op_e;

endpackage

// File: rtl/alu32_addsub.sv
// Shared adder/subtractor. Also derives signed ordering of A against B
// from the difference and its overflow.
module alu32_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             sub_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             lt_o,
    output logic             gt_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] b_eff;
    logic             ovf;
    logic             eq;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(WIDTH-1){1'b0}}, sub_i};
        // overflow of A - B: operand signs differ and the sign of the result left A's sign
        ovf   = (a_i[MSB] ^ b_i[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
        eq    = (sum_o == '0);
        lt_o  = sum_o[MSB] ^ ovf;
        gt_o  = ~lt_o & ~eq;
    end
endmodule

// File: rtl/alu32_shift.sv
// Log-depth barrel shifter producing both left and logical right shifts.
module alu32_shift #(
    parameter int WIDTH = 32,
    parameter int SHW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [SHW-1:0]   amt_i,
    output logic [WIDTH-1:0] shl_o,
    output logic [WIDTH-1:0] shr_o
);
    logic [WIDTH-1:0] lstg [0:SHW];
    logic [WIDTH-1:0] rstg [0:SHW];

    assign lstg[0] = a_i;
    assign rstg[0] = a_i;

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign lstg[k+1] = amt_i[k] ? {lstg[k][WIDTH-1-STEP:0], {STEP{1'b0}}} : lstg[k];
        assign rstg[k+1] = amt_i[k] ? {{STEP{1'b0}}, rstg[k][WIDTH-1:STEP]} : rstg[k];
    end

    assign shl_o = lstg[SHW];
    assign shr_o = rstg[SHW];
endmodule

// File: rtl/alu32_bitwise.sv
// Bitwise function unit.
module alu32_bitwise #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] and_o,
    output logic [WIDTH-1:0] or_o,
    output logic [WIDTH-1:0] xor_o,
    output logic [WIDTH-1:0] nor_o,
    output logic [WIDTH-1:0] nand_o
);
    always_comb begin
        and_o  = a_i & b_i;
        or_o   = a_i | b_i;
        xor_o  = a_i ^ b_i;
        nor_o  = ~or_o;
        nand_o = ~and_o;
    end
endmodule

// File: rtl/alu32.sv
// Top: combinational ALU with result select and zero detect.
module alu32
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o
);
    localparam int SHW = $clog2(WIDTH);

    alu_op_e          op;
    logic             do_sub;
    logic [WIDTH-1:0] sum, shl, shr;
    logic [WIDTH-1:0] f_and, f_or, f_xor, f_nor, f_nand;
    logic             lt, gt;

    assign op     = alu_op_e'(op_i);
    assign do_sub = (op != OP_ADD);

    alu32_addsub #(.WIDTH(WIDTH)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (do_sub),
        .sum_o (sum),
        .lt_o  (lt),
        .gt_o  (gt)
    );

    alu32_shift #(.WIDTH(WIDTH), .SHW(SHW)) u_shift (
        .a_i   (a_i),
        .amt_i (b_i[SHW-1:0]),
        .shl_o (shl),
        .shr_o (shr)
    );

    alu32_bitwise #(.WIDTH(WIDTH)) u_bitwise (
        .a_i    (a_i),
        .b_i    (b_i),
        .and_o  (f_and),
        .or_o   (f_or),
        .xor_o  (f_xor),
        .nor_o  (f_nor),
        .nand_o (f_nand)
    );

    always_comb begin
        unique case (op)
            OP_ADD:  result_o = sum;
            OP_SUB:  result_o = sum;
            OP_SHL:  result_o = shl;
            OP_SHR:  result_o = shr;
            OP_AND:  result_o = f_and;
            OP_OR:   result_o = f_or;
            OP_XOR:  result_o = f_xor;
            OP_NOR:  result_o = f_nor;
            OP_NAND: result_o = f_nand;
            OP_LT:   result_o = {{(WIDTH-1){1'b0}}, lt};
            OP_GT:   result_o = {{(WIDTH-1){1'b0}}, gt};
            OP_PASS: result_o = a_i;
            default: result_o = '0;
        endcase
    end

    assign zero_o = ~|result_o;
endmodule

// File: rtl/alu32_chk.sv
// Property checker attached to the ALU top through bind.
module alu32_chk
    import alu32_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] result_o,
    input  logic             zero_o
);
    localparam int SHW = $clog2(WIDTH);

    always_comb begin
        if (op_i == OP_PASS) begin
            AST_PASS_KEEPS_A: assert (result_o == a_i); // R9
        end
        if (op_i > OP_PASS) begin
            AST_SPARE_CODE_ZERO: assert (result_o == '0 && zero_o); // R10
        end
        if (op_i == OP_LT || op_i == OP_GT) begin
            AST_CMP_SINGLE_BIT: assert (result_o[WIDTH-1:1] == '0); // R7
        end
        if (op_i == OP_GT && result_o[0]) begin
            AST_GT_NOT_EQUAL: assert (a_i != b_i); // R8
        end
        if (op_i == OP_SHR && b_i[SHW-1:0] != '0) begin
            AST_SHR_TOP_CLEAR: assert (!result_o[WIDTH-1]); // R4
        end
        if (op_i == OP_SUB && a_i == b_i) begin
            AST_SUB_SELF_ZERO: assert (zero_o); // R2
        end
    end
endmodule

bind alu32 alu32_chk #(.WIDTH(WIDTH)) u_chk (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .result_o (result_o),
    .zero_o   (zero_o)
);

// File: tb/alu32_test.sv
module alu32_test;

    typedef struct {
        logic [3:0]  op;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_y;
    } item_t;

    logic        clk = 1'b0;
    logic [3:0]  op  = 4'd0;
    logic [31:0] a   = 32'd0;
    logic [31:0] b   = 32'd0;
    logic [31:0] y;
    logic        z;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;

    alu32 uut (
        .op_i     (op),
        .a_i      (a),
        .b_i      (b),
        .result_o (y),
        .zero_o   (z)
    );

    function automatic logic [31:0] model(input logic [3:0] c, input logic [31:0] x, input logic [31:0] w);
        case (c)
            4'd0:  return x + w;
            4'd1:  return x - w;
            4'd2:  return x << w[4:0];
            4'd3:  return x >> w[4:0];
            4'd4:  return x & w;
            4'd5:  return x | w;
            4'd6:  return x ^ w;
            4'd7:  return ~(x | w);
            4'd8:  return ~(x & w);
            4'd9:  return ($signed(x) < $signed(w)) ? 32'd1 : 32'd0;
            4'd10: return ($signed(x) > $signed(w)) ? 32'd1 : 32'd0;
            4'd11: return x;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4, 4'd5, 4'd6: return "R5";
            4'd7, 4'd8: return "R6";
            4'd9: return "R7";
            4'd10: return "R8";
            4'd11: return "R9";
            default: return "R10";
        endcase
    endfunction

    // driver: applies a vector on the rising edge and pushes what it expects
    task automatic apply(input logic [3:0] c, input logic [31:0] x, input logic [31:0] w);
        item_t it;
        @(posedge clk);
        op = c;
        a  = x;
        b  = w;
        it.op = c;
        it.a = x;
        it.b = w;
        it.exp_y = model(c, x, w);
        sb_q.push_back(it);
    endtask

    // monitor: compares on the falling edge, after the combinational outputs have settled
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_vec++;
            if (y !== it.exp_y) begin
                n_fail++;
                $display("FAIL %s op=%0h a=%h b=%h result actual=%h expected=%h",
                         req_of(it.op), it.op, it.a, it.b, y, it.exp_y);
            end
            if (z !== (it.exp_y == 32'd0)) begin
                n_fail++;
                $display("FAIL R11 op=%0h a=%h b=%h zero actual=%0b expected=%0b",
                         it.op, it.a, it.b, z, (it.exp_y == 32'd0));
            end
        end
    end

    initial begin
        // state after power-up: add of two zeros
        apply(4'd0, 32'd0, 32'd0);                       // R1 R11
        // R1 wrap
        apply(4'd0, 32'hFFFF_FFFF, 32'd1);
        apply(4'd0, 32'h7FFF_FFFF, 32'd1);
        // R2 borrow and self-difference
        apply(4'd1, 32'd0, 32'd1);
        apply(4'd1, 32'h1234_5678, 32'h1234_5678);
        // R3 shift amounts and ignored upper bits of B
        apply(4'd2, 32'h8000_0001, 32'd0);
        apply(4'd2, 32'h0000_0001, 32'd31);
        apply(4'd2, 32'hDEAD_BEEF, 32'hFFFF_FFE0);
        apply(4'd2, 32'h0000_0003, 32'h0000_0021);
        // R4 logical fill and ignored upper bits of B
        apply(4'd3, 32'h8000_0000, 32'd31);
        apply(4'd3, 32'hF000_0000, 32'd4);
        apply(4'd3, 32'hCAFE_F00D, 32'h0000_0020);
        // R5 R6 bitwise
        apply(4'd4, 32'hF0F0_F0F0, 32'h0F0F_0F0F);
        apply(4'd5, 32'd0, 32'd0);
        apply(4'd6, 32'hAAAA_5555, 32'hAAAA_5555);
        apply(4'd7, 32'd0, 32'd0);
        apply(4'd7, 32'hFFFF_FFFF, 32'd0);
        apply(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        apply(4'd8, 32'h1234_0000, 32'h0000_5678);
        // R7 R8 signed compares including overflow of A - B and equality
        apply(4'd9, 32'h8000_0000, 32'h7FFF_FFFF);
        apply(4'd9, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(4'd9, 32'hFFFF_FFFF, 32'd0);
        apply(4'd9, 32'd5, 32'd5);
        apply(4'd10, 32'h7FFF_FFFF, 32'h8000_0000);
        apply(4'd10, 32'h8000_0000, 32'h7FFF_FFFF);
        apply(4'd10, 32'd0, 32'hFFFF_FFFF);
        apply(4'd10, 32'h8000_0000, 32'h8000_0000);
        // R9 pass-through, including zero A with non-zero B
        apply(4'd11, 32'h89AB_CDEF, 32'h1111_1111);
        apply(4'd11, 32'd0, 32'hFFFF_FFFF);
        // R10 spare codes
        for (int c = 12; c < 16; c++) apply(4'(c), 32'hFFFF_FFFF, 32'h1234_5678);
        // random sweep over every code
        for (int c = 0; c < 16; c++) begin
            for (int i = 0; i < 150; i++) apply(4'(c), $urandom, $urandom);
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<100000", cyc);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule